// File: doc/BRIEF.md
# Discriminator Hit Timestamp Capture

This block records when each of sixteen discriminator lines fires during an acquisition window. The lines come from the high-gain half of a front-end chip and change without regard to the board clock, which runs at 100 MHz. Each line goes through its own multi-stage synchroniser. A low-to-high change seen while the window is open produces one record. The record holds the channel number and the value of a free-running time counter. The counter restarts from zero on every spill-start pulse, and the window is kept open through the spill and through the extension period after it.

Records first go to a per-channel pending stage. That stage drains one record per cycle into a FIFO, taking the lowest-numbered channel first, so channels that fire together are queued in ascending order. The FIFO output is a valid/ready stream. If a record cannot be stored, it is dropped and a sticky overflow flag is raised. The flag stays set until the next spill start or a reset.

Top module: `hit_stamp_top`

## Requirements
- R1: Each line is synchronised through SYNC_STAGES flops (default 2). Only a 0-to-1 change makes a record, so a line held high for many cycles gives exactly one record and a falling change gives none.
- R2: With the default SYNC_STAGES of 2, a line first sampled high at clock edge m gets timestamp m+1. Edges are counted with the spill-start edge as edge 0.
- R3: The time counter is zero in the cycle after a clock edge that samples spill_start high. It then rises by one every cycle and wraps modulo 2^TS_W.
- R4: rec_chan is the input bit index (0 to NUM_CH-1) of the line that fired.
- R5: Records from lines that fire in the same cycle share one timestamp and come out in ascending channel order.
- R6: A rising edge detected while acq_en is low makes no record.
- R7: When the FIFO already holds FIFO_DEPTH records, a further hit is discarded and the stored records are delivered unchanged and in order.
- R8: overflow rises when a hit is discarded. It stays high until a clock edge samples spill_start high, and it is low in the cycle after that edge.
- R9: While rec_valid is high and rec_ready is low, rec_valid, rec_chan and rec_time hold steady. Each cycle with both high delivers exactly one record.
- R10: During reset, rec_valid and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_en | input | 1 | Acquisition window; hits are recorded only while high |
| spill_start | input | 1 | One-cycle pulse that restarts the time counter and clears overflow |
| disc_in | input | NUM_CH | Asynchronous discriminator lines |
| rec_ready | input | 1 | Consumer accepts the current record |
| rec_valid | output | 1 | A record is presented |
| rec_chan | output | CH_W | Channel number of the presented record |
| rec_time | output | TS_W | Timestamp of the presented record |
| overflow | output | 1 | Sticky flag: a hit was discarded |

## Verification
A line raised just after clock edge n is first sampled at edge n+1, so it carries timestamp n+2. The bench keeps its own spill-relative cycle count and queues that expected value at the moment it drives the line. The record then passes through the pending stage and the FIFO, which takes at least three more cycles and longer under backpressure. For that reason the monitor compares records only in order, at each accepted handshake, and not at a fixed cycle. The overflow flag and the held output are checked a full cycle after the stimulus that sets them has settled.

// File: rtl/hs_pkg.sv
package hs_pkg;
   localparam int HS_MIN_SYNC = 2;

   function automatic bit hs_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/hs_sync_edge.sv
module hs_sync_edge #(
   parameter int NUM_CH      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] lines,
   output logic [NUM_CH-1:0] rise
);
   localparam int SH_W = SYNC_STAGES + 1;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic [SH_W-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[SH_W-2:0], lines[g]};
      end
      assign rise[g] = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
   end
endmodule

// File: rtl/hs_capture.sv
module hs_capture #(
   parameter int NUM_CH = 16,
   parameter int TS_W   = 16,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] rise,
   input  logic              acq_en,
   input  logic [TS_W-1:0]   now,
   input  logic              fifo_full,
   output logic              push,
   output logic [CH_W-1:0]   push_chan,
   output logic [TS_W-1:0]   push_time,
   output logic              drop
);
   logic [NUM_CH-1:0] pend_q;
   logic [NUM_CH-1:0] hit, clr, collide;
   logic [TS_W-1:0]   stamp_q [NUM_CH];
   logic              sel_valid;
   logic [CH_W-1:0]   sel_idx;

   always_comb begin
      sel_valid = |pend_q;
      sel_idx   = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (pend_q[i]) sel_idx = CH_W'(i);
      end
   end

   assign push      = sel_valid & ~fifo_full;
   assign push_chan = sel_idx;
   assign push_time = stamp_q[sel_idx];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
      assign hit[g]     = rise[g] & acq_en;
      assign clr[g]     = sel_valid && (sel_idx == CH_W'(g));
      assign collide[g] = hit[g] & pend_q[g] & ~clr[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q[g]  <= 1'b0;
            stamp_q[g] <= '0;
         end else begin
            pend_q[g] <= (pend_q[g] & ~clr[g]) | hit[g];
            if (hit[g] && !collide[g]) stamp_q[g] <= now;
         end
      end
   end

   assign drop = (sel_valid & fifo_full) | (|collide);
endmodule

// File: rtl/hs_fifo.sv
module hs_fifo #(
   parameter int WIDTH = 20,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rd,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr_q, rptr_q;
   logic [AW:0]      cnt_q;
   logic             do_wr, do_rd;

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == (AW+1)'(DEPTH));
   assign do_wr = wr & ~full;
   assign do_rd = rd & ~empty;
   assign rdata = mem[rptr_q];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_wr) wptr_q <= wptr_q + 1'b1;
         if (do_rd) rptr_q <= rptr_q + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/hit_stamp_top.sv
module hit_stamp_top #(
   parameter int NUM_CH      = 16,
   parameter int TS_W        = 16,
   parameter int FIFO_DEPTH  = 16,
   parameter int SYNC_STAGES = 2,
   localparam int CH_W       = $clog2(NUM_CH),
   localparam int REC_W      = CH_W + TS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acq_en,
   input  logic              spill_start,
   input  logic [NUM_CH-1:0] disc_in,
   input  logic              rec_ready,
   output logic              rec_valid,
   output logic [CH_W-1:0]   rec_chan,
   output logic [TS_W-1:0]   rec_time,
   output logic              overflow
);
   import hs_pkg::*;

   if (SYNC_STAGES < HS_MIN_SYNC) begin : g_bad_sync
      $error("SYNC_STAGES below minimum");
   end
   if (!hs_is_pow2(FIFO_DEPTH)) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two");
   end
   if (NUM_CH < 2 || TS_W < 2) begin : g_bad_width
      $error("NUM_CH and TS_W must be at least 2");
   end

   logic [NUM_CH-1:0] rise;
   logic [TS_W-1:0]   time_q;
   logic              push, drop, fifo_full, fifo_empty;
   logic [CH_W-1:0]   push_chan;
   logic [TS_W-1:0]   push_time;
   logic [REC_W-1:0]  head;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           time_q <= '0;
      else if (spill_start) time_q <= '0;
      else                  time_q <= time_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           overflow <= 1'b0;
      else if (spill_start) overflow <= 1'b0;
      else if (drop)        overflow <= 1'b1;
   end

   hs_sync_edge #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .lines(disc_in), .rise(rise)
   );

   hs_capture #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .rise(rise), .acq_en(acq_en), .now(time_q),
      .fifo_full(fifo_full), .push(push), .push_chan(push_chan),
      .push_time(push_time), .drop(drop)
   );

   hs_fifo #(.WIDTH(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr(push), .wdata({push_chan, push_time}),
      .rd(rec_valid & rec_ready), .rdata(head), .empty(fifo_empty),
      .full(fifo_full)
   );

   assign rec_valid = ~fifo_empty;
   assign rec_chan  = head[REC_W-1:TS_W];
   assign rec_time  = head[TS_W-1:0];
endmodule

// File: rtl/hs_checker.sv
module hs_checker #(
   parameter int CH_W = 4,
   parameter int TS_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            spill_start,
   input logic            rec_valid,
   input logic            rec_ready,
   input logic [CH_W-1:0] rec_chan,
   input logic [TS_W-1:0] rec_time,
   input logic            overflow,
   input logic [TS_W-1:0] time_q
);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && !rec_ready |=> rec_valid && $stable(rec_chan) && $stable(rec_time));

   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      overflow && !spill_start |=> overflow);

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      spill_start |=> !overflow);

   p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      spill_start |=> time_q == '0);

   always @(negedge clk) begin
      if (!rst_n) p_reset_r10: assert (!rec_valid && !overflow);
   end
endmodule

bind hit_stamp_top hs_checker #(.CH_W(CH_W), .TS_W(TS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .spill_start(spill_start), .rec_valid(rec_valid),
   .rec_ready(rec_ready), .rec_chan(rec_chan), .rec_time(rec_time),
   .overflow(overflow), .time_q(time_q)
);

// File: tb/hit_stamp_top_tb.sv
module hit_stamp_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NCH  = 16;
   localparam int TSW  = 10;
   localparam int DEP  = 16;
   localparam int CW   = 4;

   logic clk = 0, rst_n = 0, acq_en = 0, spill_start = 0, rec_ready = 1;
   logic [NCH-1:0] disc_in = '0;
   logic rec_valid, overflow;
   logic [CW-1:0] rec_chan;
   logic [TSW-1:0] rec_time;

   int errors = 0, checks = 0;
   bit done = 0;
   logic [TSW-1:0] bt = '0;
   logic [CW+TSW-1:0] exp_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   hit_stamp_top #(.NUM_CH(NCH), .TS_W(TSW), .FIFO_DEPTH(DEP), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .spill_start(spill_start),
      .disc_in(disc_in), .rec_ready(rec_ready), .rec_valid(rec_valid),
      .rec_chan(rec_chan), .rec_time(rec_time), .overflow(overflow)
   );

   // R3 model: spill-relative cycle count
   always @(posedge clk) bt <= spill_start ? '0 : bt + 1'b1;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // monitor: R4 R5 R9 in-order scoreboard
   initial begin
      forever begin
         @(negedge clk); #1;
         if (rst_n && rec_valid && rec_ready) begin
            if (exp_q.size() == 0) begin
               check(0, "R7/R9 unexpected record", int'({rec_chan, rec_time}), -1);
            end else begin
               logic [CW+TSW-1:0] e;
               e = exp_q.pop_front();
               check(rec_chan == e[CW+TSW-1:TSW], "R4/R5 chan", rec_chan, e[CW+TSW-1:TSW]);
               check(rec_time == e[TSW-1:0], "R2/R3 time", rec_time, e[TSW-1:0]);
            end
         end
      end
   end

   task automatic spill();
      @(negedge clk); spill_start = 1;
      @(negedge clk); spill_start = 0;
   endtask

   task automatic fire(input logic [NCH-1:0] mask, input bit keep, input int hold);
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
         if (mask[c] && keep && acq_en) begin
            logic [TSW-1:0] st;
            st = bt + 2'd2;
            exp_q.push_back({CW'(c), st});
         end
      end
      disc_in = mask;
      repeat (hold) @(negedge clk);
      disc_in = '0;
      repeat (18) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk); #1;
      check(!rec_valid, "R10 valid in reset", rec_valid, 0);
      check(!overflow, "R10 overflow in reset", overflow, 0);
      rst_n = 1;
      acq_en = 1;
      spill();
      fire(16'h0001, 1, 4);          // R2 single
      fire(16'h8000, 1, 4);          // R4 top channel
      fire(16'h8421, 1, 4);          // R5 ascending
      fire(16'hFFFF, 1, 4);          // R5 all channels
      fire(16'h0040, 1, 30);         // R1 held high -> one record
      repeat (20) @(negedge clk); #1;
      check(exp_q.size() == 0, "R1 records drained", exp_q.size(), 0);
      // R6: window closed
      acq_en = 0;
      fire(16'h0300, 1, 4);
      #1;
      check(!rec_valid, "R6 no record when closed", rec_valid, 0);
      acq_en = 1;
      // R7 R8 R9: backpressure, overflow
      spill();
      @(negedge clk); rec_ready = 0;
      for (int k = 0; k < DEP; k++) fire(NCH'(1) << (k % NCH), 1, 3);
      #1;
      check(!overflow, "R7 full but no drop yet", overflow, 0);
      for (int k = 0; k < 3; k++) fire(16'h0010, 0, 3);
      #1;
      check(overflow, "R8 overflow set", overflow, 1);
      check(rec_valid, "R9 valid held", rec_valid, 1);
      check({rec_chan, rec_time} == exp_q[0], "R9 head held", int'({rec_chan, rec_time}), int'(exp_q[0]));
      @(negedge clk); rec_ready = 1;
      repeat (40) @(negedge clk); #1;
      check(exp_q.size() == 0, "R7 stored records delivered", exp_q.size(), 0);
      check(overflow, "R8 overflow sticky", overflow, 1);
      spill(); #1;
      check(!overflow, "R8 overflow cleared by spill", overflow, 0);
      // R3: counter wrap
      spill();
      repeat (1000) @(negedge clk);
      fire(16'h0008, 1, 4);
      fire(16'h0004, 1, 4);
      repeat (10) @(negedge clk); #1;
      check(exp_q.size() == 0, "R3 wrap records drained", exp_q.size(), 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule